// File: doc/BRIEF.md
# Sync-Started Single-Cycle PWM Generator

This block produces a high-side PWM waveform from a period value and a duty value, each given in clock counts with four fractional bits below the integer part. It has two ways to begin a cycle. In free-running mode, cycles follow one another with no gap. In sync mode, the generator waits low until it samples a pulse on its sync input. It then runs exactly one cycle and goes idle again.

A common use pairs two instances. The reference instance runs free. A delayed copy of its start-of-cycle trigger drives the sync input of the second instance. The second output is then a phase-shifted copy of the first, and the delay sets the shift.

A trigger output pulses for one clock at a programmable count within each running cycle. A compare value of zero places the pulse on the first clock of the cycle.

Top module: `sync_pwm_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `pwm_h` and `trig_out` are low and no cycle runs.
- R2: Only the integer part of each value (value >> 4) is used. A cycle lasts period>>4 clocks, and `pwm_h` is high for the first duty>>4 clocks of it. Bits [3:0] of every value have no effect.
- R3: In free-running mode (`sync_mode` = 0), the count wraps from period-1 to 0 and the next cycle starts at once, with no idle clock between cycles.
- R4: On the first clock edge that samples `enable` high, the count is cleared. In free-running mode, the first cycle begins on the following edge, so `pwm_h` first rises after the second edge.
- R5: While `enable` is low, no cycle runs, and both outputs are low after the next edge.
- R6: In sync mode (`sync_mode` = 1), a high `sync_in` sampled while idle starts one cycle on that edge. That cycle is followed by idle until the next sync.
- R7: In sync mode, `sync_in` has no effect while a cycle is running.
- R8: In sync mode, `pwm_h` and `trig_out` stay low while the block waits for sync.
- R9: `trig_out` is high for exactly one clock in each running cycle, at count trig>>4. A value of 0 places it on the first clock of the cycle.
- R10: When duty>>4 is at least period>>4, `pwm_h` is high for the whole cycle. When duty>>4 is 0, `pwm_h` stays low.
- R11: A period whose integer part is 0 or 1 gives one-clock cycles.
- R12: The mode is sampled at the end of each cycle. A change made in the middle of a cycle decides only what happens when that cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run enable; a rising edge restarts the count |
| sync_mode | input | 1 | 0 = free-running, 1 = one cycle per sync pulse |
| period_q | input | CNT_W+4 | Cycle length, integer part plus four fractional bits |
| duty_q | input | CNT_W+4 | High time, same format |
| trig_q | input | CNT_W+4 | Trigger compare point, same format |
| sync_in | input | 1 | Cycle start request used in sync mode |
| pwm_h | output | 1 | High-side PWM output |
| trig_out | output | 1 | One-clock trigger pulse inside each cycle |

## Verification
Both outputs are combinational decodes of the count register. Any input sampled at an edge therefore shows up at the outputs one clock later. The one exception is enable in free-running mode: it needs two edges, because the first edge only clears the count. The bench keeps a behavioural model that advances on the same rising edge and compares both outputs on every falling edge, so each result is checked in the cycle it becomes due. Directed checks count the clocks from an enable or sync stimulus to the first high output, and tally the high and trigger clocks over a window after each sync pulse. This catches a cycle that repeats or runs short.

// File: rtl/pwm_pkg.sv
// Package: shared mode type and format constants for the sync-started PWM generator.
// Assumes all configuration values carry FRAC_BITS fractional bits below the integer count.
package pwm_pkg;

    localparam int FRAC_BITS = 4;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_SYNC = 1'b1
    } start_mode_e;

endpackage

// File: rtl/pwm_cfg_decode.sv
// Module: pwm_cfg_decode
// Strips the fractional bits from the period, duty and trigger values and
// derives the terminal count of a cycle. Assumes the fractional bits carry no
// timing meaning. A period whose integer part is zero is treated as one clock.
module pwm_cfg_decode #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4,
    localparam int REG_W = CNT_W + FRAC_W
) (
    input  logic [REG_W-1:0] period_q,
    input  logic [REG_W-1:0] duty_q,
    input  logic [REG_W-1:0] trig_q,
    output logic [CNT_W-1:0] duty_int,
    output logic [CNT_W-1:0] trig_int,
    output logic [CNT_W-1:0] last_cnt
);

    logic [CNT_W-1:0] per_int;

    // Purpose: keep the integer parts of the three values.
    always_comb begin
        per_int  = period_q[REG_W-1:FRAC_W];
        duty_int = duty_q[REG_W-1:FRAC_W];
        trig_int = trig_q[REG_W-1:FRAC_W];
    end

    // Purpose: terminal count is period-1, and 0 for a zero or one-clock period.
    always_comb begin
        if (per_int == '0) begin
            last_cnt = '0;
        end else begin
            last_cnt = per_int - 1'b1;
        end
    end

endmodule

// File: rtl/pwm_start_ctl.sv
// Module: pwm_start_ctl
// Decides when the cycle counter is cleared and when a new cycle begins.
// It tracks the enable level to find its rising edge. Assumes sync_in is
// already synchronous to clk.
module pwm_start_ctl
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  start_mode_e mode,
    input  logic        sync_in,
    input  logic        running,
    output logic        clear,
    output logic        start
);

    logic en_d;

    // Purpose: remember last cycle's enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d <= 1'b0;
        end else begin
            en_d <= enable;
        end
    end

    // Purpose: clear while disabled or on the enable edge; start only from idle.
    always_comb begin
        clear = !enable || !en_d;
        start = 1'b0;
        if (!clear && !running) begin
            start = (mode == MODE_FREE) || sync_in;
        end
    end

endmodule

// File: rtl/pwm_cycle_counter.sv
// Module: pwm_cycle_counter
// Holds the running flag and the integer count of the current cycle. At the
// terminal count it wraps in free-running mode and stops in sync mode. Assumes
// clear takes priority over start, and start is raised only while idle.
module pwm_cycle_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  start_mode_e      mode,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             cycle_end
);

    // Purpose: flag the last clock of a running cycle (>= survives a shrinking period).
    always_comb begin
        cycle_end = running && (count >= last_cnt);
    end

    // Purpose: advance, wrap or stop the cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            count   <= '0;
        end else if (clear) begin
            running <= 1'b0;
            count   <= '0;
        end else if (start) begin
            running <= 1'b1;
            count   <= '0;
        end else if (running) begin
            if (cycle_end) begin
                count <= '0;
                if (mode == MODE_SYNC) begin
                    running <= 1'b0;
                end
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> (running && count == '0)); // R6
    AST_SYNC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && mode == MODE_SYNC && !clear) |=> !running); // R6
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && mode == MODE_FREE && !clear) |=> (running && count == '0)); // R3
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cycle_end && !clear) |=> (running && count == $past(count) + 1'b1)); // R7

endmodule

// File: rtl/pwm_out_compare.sv
// Module: pwm_out_compare
// Turns the cycle count into the high-side output and the one-clock trigger.
// Assumes count restarts at zero at the start of each cycle. Both outputs are
// forced low while no cycle runs.
module pwm_out_compare #(
    parameter int CNT_W = 16
) (
    input  logic             running,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] duty_int,
    input  logic [CNT_W-1:0] trig_int,
    output logic             pwm_h,
    output logic             trig_out
);

    // Purpose: high below the duty count; trigger pulses on the compare count.
    always_comb begin
        pwm_h    = running && (count < duty_int);
        trig_out = running && (count == trig_int);
    end

endmodule

// File: rtl/sync_pwm_gen.sv
// Module: sync_pwm_gen (top)
// PWM generator that either runs freely or produces one cycle per sync pulse.
// Assumes all inputs are synchronous to clk. The period, duty and trigger
// values carry four fractional bits that the timing does not use.
module sync_pwm_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int REG_W = CNT_W + FRAC_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sync_mode,
    input  logic [REG_W-1:0] period_q,
    input  logic [REG_W-1:0] duty_q,
    input  logic [REG_W-1:0] trig_q,
    input  logic             sync_in,
    output logic             pwm_h,
    output logic             trig_out
);

    start_mode_e      mode;
    logic [CNT_W-1:0] duty_int;
    logic [CNT_W-1:0] trig_int;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             cycle_end;
    logic             clear;
    logic             start;

    // Purpose: map the mode pin onto the shared enum.
    always_comb begin
        mode = sync_mode ? MODE_SYNC : MODE_FREE;
    end

    pwm_cfg_decode #(.CNT_W(CNT_W), .FRAC_W(FRAC_BITS)) u_decode (
        .period_q (period_q),
        .duty_q   (duty_q),
        .trig_q   (trig_q),
        .duty_int (duty_int),
        .trig_int (trig_int),
        .last_cnt (last_cnt)
    );

    pwm_start_ctl u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (mode),
        .sync_in (sync_in),
        .running (running),
        .clear   (clear),
        .start   (start)
    );

    pwm_cycle_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .start     (start),
        .mode      (mode),
        .last_cnt  (last_cnt),
        .running   (running),
        .count     (count),
        .cycle_end (cycle_end)
    );

    pwm_out_compare #(.CNT_W(CNT_W)) u_compare (
        .running  (running),
        .count    (count),
        .duty_int (duty_int),
        .trig_int (trig_int),
        .pwm_h    (pwm_h),
        .trig_out (trig_out)
    );

    AST_DIS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pwm_h && !trig_out)); // R5
    AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !sync_in && !running) |=> (!pwm_h && !trig_out)); // R8

endmodule

// File: tb/tb_sync_pwm_gen.sv
`timescale 1ns/1ps
module tb_sync_pwm_gen;

    localparam int CW = 16;
    localparam int RW = CW + 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable;
    logic          sync_mode;
    logic [RW-1:0] period_q;
    logic [RW-1:0] duty_q;
    logic [RW-1:0] trig_q;
    logic          sync_in;
    logic          pwm_h;
    logic          trig_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_run = 0;
    int m_cnt = 0;
    int m_en_d = 0;

    always #2.5 clk = ~clk;

    sync_pwm_gen #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
        .period_q(period_q), .duty_q(duty_q), .trig_q(trig_q),
        .sync_in(sync_in), .pwm_h(pwm_h), .trig_out(trig_out)
    );

    // behavioural reference, advanced on the same edge as the design
    always @(posedge clk) begin
        int per;
        per = int'(period_q >> 4);
        if (per < 1) per = 1;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_en_d = 0;
        end else begin
            if (!enable || !m_en_d) begin
                m_run = 0; m_cnt = 0;
            end else if (m_run == 0) begin
                if (!sync_mode || sync_in) begin
                    m_run = 1; m_cnt = 0;
                end
            end else if (m_cnt >= per - 1) begin
                m_cnt = 0;
                if (sync_mode) m_run = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_en_d = enable;
        end
    end

    function automatic bit exp_pwm();
        return (m_run != 0) && (m_cnt < int'(duty_q >> 4));
    endfunction

    function automatic bit exp_trig();
        return (m_run != 0) && (m_cnt == int'(trig_q >> 4));
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, int'(pwm_h), int'(exp_pwm()), "pwm_h vs model");
            check(cur_req, int'(trig_out), int'(exp_trig()), "trig_out vs model");
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        int tr;
        rst_n = 1'b0; enable = 1'b0; sync_mode = 1'b0; sync_in = 1'b0;
        period_q = '0; duty_q = '0; trig_q = '0;
        tick(3);
        check("R1", int'(pwm_h), 0, "pwm_h in reset");
        check("R1", int'(trig_out), 0, "trig_out in reset");
        rst_n = 1'b1;
        tick(1);
        check("R1", int'(pwm_h), 0, "pwm_h after reset");

        // free-running, fractional bits set to show they are dropped
        cur_req = "R3";
        period_q = RW'((10 << 4) | 5);
        duty_q = RW'((4 << 4) | 9);
        trig_q = RW'(0 | 3);
        enable = 1'b1;
        tick(1);
        check("R4", int'(pwm_h), 0, "pwm_h one edge after enable");
        tick(1);
        check("R4", int'(pwm_h), 1, "pwm_h two edges after enable");
        check("R9", int'(trig_out), 1, "trigger on first clock with compare 0");
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            hi += int'(pwm_h);
            tick(1);
        end
        check("R2", hi, 4, "high clocks per cycle");
        check("R3", int'(pwm_h), 1, "next cycle starts with no gap");
        tick(25);

        cur_req = "R10";
        duty_q = RW'(15 << 4);
        tick(25);
        duty_q = '0;
        tick(25);

        cur_req = "R11";
        duty_q = RW'(1 << 4);
        period_q = RW'(1 << 4);
        tick(8);
        period_q = RW'(7);
        tick(8);

        cur_req = "R5";
        enable = 1'b0;
        tick(1);
        check("R5", int'(pwm_h), 0, "pwm_h after disable");
        tick(6);

        // sync mode
        cur_req = "R8";
        sync_mode = 1'b1;
        period_q = RW'((8 << 4) | 15);
        duty_q = RW'((3 << 4) | 1);
        trig_q = RW'((2 << 4) | 11);
        enable = 1'b1;
        tick(6);
        check("R8", int'(pwm_h), 0, "waiting for sync");
        cur_req = "R6";
        sync_in = 1'b1;
        tick(1);
        sync_in = 1'b0;
        check("R6", int'(pwm_h), 1, "pwm_h one clock after sync");
        hi = 0; tr = 0;
        for (int i = 0; i < 20; i++) begin
            hi += int'(pwm_h);
            tr += int'(trig_out);
            if (i == 4) sync_in = 1'b1;
            if (i == 5) sync_in = 1'b0;
            tick(1);
        end
        check("R7", hi, 3, "high clocks after one sync with mid-cycle sync");
        check("R9", tr, 1, "trigger pulses in single cycle");

        cur_req = "R6";
        sync_in = 1'b1;
        tick(30);
        sync_in = 1'b0;
        tick(12);

        // mode change mid-cycle
        cur_req = "R12";
        sync_in = 1'b1;
        tick(1);
        sync_in = 1'b0;
        tick(3);
        sync_mode = 1'b0;
        tick(20);
        sync_mode = 1'b1;
        tick(20);
        check("R12", int'(pwm_h), 0, "idle after returning to sync mode");

        finish_run();
    end

endmodule